// File: doc/BRIEF.md
# Masked Fault Latch Register Bank

This block watches the condition flags of several output channels and turns selected flags into latched faults that a host can collect. Each channel has three 8-bit registers. The status word comes straight from hardware. The mask word is written by the host and chooses which conditions may raise a fault. The fault word latches the enabled conditions until the host reads it. A fault bit fires on a rising edge of its condition while enabled. It also fires when an active condition is newly enabled. Reading a fault word hands back its contents and empties it in the same cycle.

A channel that the host has just re-programmed can be re-armed with a single strobe. The strobe fires the regulation-mode bits (CV, +CC, -CC, UNR) again if they are enabled and active, even though no edge has occurred. Every channel's fault word is reduced to one flag. These flags sit in the low bits of a summary poll word, and four flags from elsewhere in the system sit above them.

Top module: `fault_bank`

## Requirements
- R1: Each channel keeps its own mask and fault word. After reset every mask and fault word is 0. A mask write to one channel changes only that channel's mask, and the new value reads back on `mask_rd_o` from the next cycle on.
- R2: A status bit that goes from 0 to 1 while its mask bit is 1 sets the matching fault bit at the next clock edge.
- R3: A mask bit written from 0 to 1 while its status bit is 1 sets the matching fault bit at the next clock edge.
- R4: While `flt_rd_i` is high, `flt_rd_o` shows the addressed channel's fault word. That word is cleared at the next clock edge.
- R5: After a clearing read, a fault bit stays 0 while its status and mask bits both stay 1 and nothing else happens.
- R6: A fault bit stays set after its condition falls back to 0, until the word is read.
- R7: A re-arm strobe on a channel sets fault bits 0, 1, 2 and 7 wherever both the mask bit and the status bit are 1. It never sets bits 3 to 6, and it sets nothing where the mask bit is 0.
- R8: Fault bit positions: CV bit 0 (weight 1), +CC bit 1, -CC bit 2, OV bit 3 (weight 8), OC bit 4, OT bit 5, RI bit 6, UNR bit 7.
- R9: `poll_o` bits 7, 6, 5 and 4 carry `pon_i`, `rqs_i`, `err_i` and `rdy_i`. Bit k (k below 4) is 1 exactly when any fault bit of channel k is 1.
- R10: If a set event and a clearing read hit the same bit in the same cycle, the read returns the old value and the bit is 1 afterwards.
- R11: A status rising edge on a bit whose mask bit is 0 leaves the fault word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| status_i | input | 32 | Condition flags, channel k in bits 8k+7..8k |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_ch_i | input | 2 | Channel addressed by the mask write |
| mask_data_i | input | 8 | New mask value |
| mask_rd_ch_i | input | 2 | Channel whose mask is shown |
| mask_rd_o | output | 8 | Mask of the selected channel |
| flt_rd_i | input | 1 | Fault read strobe (clear on read) |
| flt_ch_i | input | 2 | Channel addressed by the fault read |
| flt_rd_o | output | 8 | Fault word of the addressed channel |
| rearm_i | input | 1 | Re-arm strobe from a setting command |
| rearm_ch_i | input | 2 | Channel the re-arm applies to |
| pon_i | input | 1 | Power-on flag for poll bit 7 |
| rqs_i | input | 1 | Request flag for poll bit 6 |
| err_i | input | 1 | Error flag for poll bit 5 |
| rdy_i | input | 1 | Ready flag for poll bit 4 |
| poll_o | output | 8 | Summary poll word |

## Verification
On every cycle the assertions check several rules. Every computed set event lands in the fault word. A bit rises only when a set event explains it. Without a read, no bit falls. A read with no competing event empties the word. The poll flags track their channels' fault words, and mask writes take effect. Only the scenarios in the bench can show where the set events come from. These are the edge-versus-level behaviour after a clearing read, unmasking an active condition, the exact bit set picked by a re-arm, and masked-off edges being ignored.

// File: rtl/fault_bank_pkg.sv
package fault_bank_pkg;
  localparam int FLT_W = 8;
  localparam int POLL_HI = 4;
  typedef logic [FLT_W-1:0] flt_t;

  localparam int BIT_CV  = 0;
  localparam int BIT_CCP = 1;
  localparam int BIT_CCN = 2;
  localparam int BIT_OV  = 3;
  localparam int BIT_OC  = 4;
  localparam int BIT_OT  = 5;
  localparam int BIT_RI  = 6;
  localparam int BIT_UNR = 7;

  // regulation-mode bits that a setting command re-fires (R7, R8)
  localparam flt_t REARM_SEL = flt_t'((1 << BIT_CV) | (1 << BIT_CCP) |
                                      (1 << BIT_CCN) | (1 << BIT_UNR));

  function automatic flt_t rise_of(input flt_t now_v, input flt_t was_v);
    return now_v & ~was_v;
  endfunction

  // bits that latch this cycle
  function automatic flt_t set_bits(input flt_t stat_rise, input flt_t mask_eff,
                                    input flt_t mask_rise, input flt_t status,
                                    input logic rearm);
    flt_t re;
    re = rearm ? (REARM_SEL & mask_eff & status) : '0;
    return (stat_rise & mask_eff) | (mask_rise & status) | re;
  endfunction

  // a new event beats a same-cycle clear (R10)
  function automatic flt_t fault_update(input flt_t cur, input flt_t set_v,
                                        input logic clr);
    return (clr ? '0 : cur) | set_v;
  endfunction
endpackage

// File: rtl/fault_chan.sv
module fault_chan
  import fault_bank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  flt_t status_i,
  input  logic mask_we_i,
  input  flt_t mask_wd_i,
  input  logic clr_i,
  input  logic rearm_i,
  output flt_t mask_o,
  output flt_t fault_o,
  output logic any_o
);
  flt_t stat_q, mask_q, fault_q;
  flt_t stat_rise_w, mask_rise_w, mask_eff_w, set_evt_w, fault_d;

  always_comb begin
    stat_rise_w = rise_of(status_i, stat_q);
    mask_eff_w  = mask_we_i ? mask_wd_i : mask_q;
    mask_rise_w = mask_we_i ? rise_of(mask_wd_i, mask_q) : '0;
    set_evt_w   = set_bits(stat_rise_w, mask_eff_w, mask_rise_w, status_i, rearm_i);
    fault_d     = fault_update(fault_q, set_evt_w, clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      mask_q  <= '0;
      fault_q <= '0;
    end else begin
      stat_q  <= status_i;
      fault_q <= fault_d;
      if (mask_we_i) mask_q <= mask_wd_i;
    end
  end

  assign mask_o  = mask_q;
  assign fault_o = fault_q;
  assign any_o   = |fault_q;

  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt_w != '0) |=> ((fault_q & $past(set_evt_w)) == $past(set_evt_w))); // R2
  AST_RISE_EXPLAINED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fault_q & ~$past(fault_q) & ~$past(set_evt_w)) == '0)); // R11
  AST_STICKY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((fault_q & $past(fault_q)) == $past(fault_q))); // R6
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_evt_w == '0) |=> (fault_q == '0)); // R4
  AST_MASK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> (mask_o == $past(mask_wd_i))); // R1
endmodule

// File: rtl/fault_poll.sv
module fault_poll #(
  parameter int NUM_CH = 4
) (
  input  logic              pon_i,
  input  logic              rqs_i,
  input  logic              err_i,
  input  logic              rdy_i,
  input  logic [NUM_CH-1:0] fau_i,
  output logic [NUM_CH+3:0] poll_o
);
  // R9: system flags above the per-channel fault flags
  assign poll_o = {pon_i, rqs_i, err_i, rdy_i, fau_i};
endmodule

// File: rtl/fault_bank.sv
module fault_bank
  import fault_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int POLL_W = NUM_CH + POLL_HI
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH*FLT_W-1:0] status_i,
  input  logic                    mask_wr_i,
  input  logic [CH_W-1:0]         mask_ch_i,
  input  logic [FLT_W-1:0]        mask_data_i,
  input  logic [CH_W-1:0]         mask_rd_ch_i,
  output logic [FLT_W-1:0]        mask_rd_o,
  input  logic                    flt_rd_i,
  input  logic [CH_W-1:0]         flt_ch_i,
  output logic [FLT_W-1:0]        flt_rd_o,
  input  logic                    rearm_i,
  input  logic [CH_W-1:0]         rearm_ch_i,
  input  logic                    pon_i,
  input  logic                    rqs_i,
  input  logic                    err_i,
  input  logic                    rdy_i,
  output logic [POLL_W-1:0]       poll_o
);
  flt_t mask_w  [NUM_CH];
  flt_t fault_w [NUM_CH];
  logic [NUM_CH-1:0] fau_w;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic we_w, clr_w, ra_w;
    assign we_w  = mask_wr_i && (mask_ch_i == CH_W'(i));
    assign clr_w = flt_rd_i && (flt_ch_i == CH_W'(i));
    assign ra_w  = rearm_i && (rearm_ch_i == CH_W'(i));

    fault_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .status_i  (status_i[i*FLT_W +: FLT_W]),
      .mask_we_i (we_w),
      .mask_wd_i (mask_data_i),
      .clr_i     (clr_w),
      .rearm_i   (ra_w),
      .mask_o    (mask_w[i]),
      .fault_o   (fault_w[i]),
      .any_o     (fau_w[i])
    );

    AST_POLL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      poll_o[i] == (fault_w[i] != '0)); // R9
  end

  assign mask_rd_o = mask_w[mask_rd_ch_i];
  assign flt_rd_o  = fault_w[flt_ch_i];

  fault_poll #(.NUM_CH(NUM_CH)) u_poll (
    .pon_i  (pon_i),
    .rqs_i  (rqs_i),
    .err_i  (err_i),
    .rdy_i  (rdy_i),
    .fau_i  (fau_w),
    .poll_o (poll_o)
  );
endmodule

// File: tb/fault_bank_test.sv
module fault_bank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] status_i = '0;
  logic mask_wr_i = 1'b0;
  logic [1:0] mask_ch_i = '0, mask_rd_ch_i = '0, flt_ch_i = '0, rearm_ch_i = '0;
  logic [7:0] mask_data_i = '0;
  logic [7:0] mask_rd_o, flt_rd_o, poll_o;
  logic flt_rd_i = 1'b0, rearm_i = 1'b0;
  logic pon_i = 1'b0, rqs_i = 1'b0, err_i = 1'b0, rdy_i = 1'b0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  fault_bank uut (.*);

  // row: status, mask write, mask value, read, rearm, expected read, expected flag
  localparam logic [27:0] VEC [24] = '{
    {8'h00, 1'b1, 8'h09, 1'b0, 1'b0, 8'h00, 1'b0},
    {8'h08, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1}, // R2 OV edge
    {8'h08, 1'b0, 8'h00, 1'b1, 1'b0, 8'h08, 1'b0}, // R4 R8 OV weight 8
    {8'h08, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0}, // R5
    {8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0},
    {8'h10, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0}, // R11 masked edge
    {8'h10, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0}, // R11
    {8'h11, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1}, // R2 CV edge
    {8'h10, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1}, // R6
    {8'h10, 1'b0, 8'h00, 1'b1, 1'b0, 8'h01, 1'b0}, // R6 R8 CV weight 1
    {8'h10, 1'b1, 8'h19, 1'b0, 1'b0, 8'h00, 1'b1}, // R3 unmask active OC
    {8'h10, 1'b0, 8'h00, 1'b1, 1'b0, 8'h10, 1'b0}, // R3
    {8'h18, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1}, // R2
    {8'h18, 1'b0, 8'h00, 1'b1, 1'b0, 8'h08, 1'b0}, // R2
    {8'h18, 1'b1, 8'h9F, 1'b0, 1'b0, 8'h00, 1'b0}, // R3 unmask inactive
    {8'h9F, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1}, // R2
    {8'h9F, 1'b0, 8'h00, 1'b1, 1'b0, 8'h87, 1'b0}, // R4
    {8'h9F, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0}, // R5
    {8'h9F, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b1}, // R7
    {8'h9F, 1'b0, 8'h00, 1'b1, 1'b0, 8'h87, 1'b0}, // R7 R8 no OV/OC
    {8'h9F, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 1'b1}, // R10
    {8'h9F, 1'b0, 8'h00, 1'b1, 1'b0, 8'h87, 1'b0}, // R10
    {8'h9F, 1'b1, 8'h08, 1'b0, 1'b0, 8'h00, 1'b0},
    {8'h9F, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0}  // R7 masked off
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    mask_wr_i = 1'b0; flt_rd_i = 1'b0; rearm_i = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      mask_rd_ch_i = 2'(c); flt_ch_i = 2'(c); #1;
      check("R1 reset mask", mask_rd_o, 8'h00);
      check("R1 reset fault", flt_rd_o, 8'h00);
    end
    check("R9 reset poll", poll_o, 8'h00);
    // R9 upper flags
    pon_i = 1; rqs_i = 0; err_i = 1; rdy_i = 0; #1;
    check("R9 flag bits", poll_o, 8'hA0);
    pon_i = 0; err_i = 0;

    // vector table on channel 1
    flt_ch_i = 2'd1; mask_ch_i = 2'd1; rearm_ch_i = 2'd1;
    for (int v = 0; v < 24; v++) begin
      @(negedge clk);
      status_i[15:8] = VEC[v][27:20];
      mask_wr_i = VEC[v][19];
      mask_data_i = VEC[v][18:11];
      flt_rd_i = VEC[v][10];
      rearm_i = VEC[v][9];
      #1;
      if (VEC[v][10]) check($sformatf("row %0d read", v), flt_rd_o, VEC[v][8:1]);
      @(posedge clk); #1;
      idle();
      check($sformatf("row %0d R9 flag", v), {7'd0, poll_o[1]}, {7'd0, VEC[v][0]});
    end

    // R1 mask isolation and readback
    mask_rd_ch_i = 2'd1; #1;
    check("R1 ch1 mask", mask_rd_o, 8'h08);
    mask_rd_ch_i = 2'd0; #1;
    check("R1 ch0 mask untouched", mask_rd_o, 8'h00);

    // R1 R9 channel independence: fault on ch3 only
    @(negedge clk);
    mask_wr_i = 1; mask_ch_i = 2'd3; mask_data_i = 8'h20;
    @(negedge clk); idle();
    status_i[31:24] = 8'h20;
    @(posedge clk); #1;
    check("R9 ch3 flag", poll_o, 8'h08);
    status_i[31:24] = 8'h00;
    @(negedge clk);
    flt_ch_i = 2'd2; flt_rd_i = 1; #1;
    check("R1 ch2 empty", flt_rd_o, 8'h00);
    @(posedge clk); #1; idle();
    check("R1 ch3 kept", poll_o, 8'h08);
    @(negedge clk);
    flt_ch_i = 2'd3; flt_rd_i = 1; #1;
    check("R4 R8 ch3 OT", flt_rd_o, 8'h20);
    @(posedge clk); #1; idle();
    check("R4 ch3 cleared", poll_o, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule